// File: doc/BRIEF.md
# Four-Digit Gated Frequency Meter

The block counts the rising edges of a pulse train during a fixed time window and shows the result as four decimal digits on seven-segment displays. A slow reference clock sets the window. A toggle flag on that clock opens a gate for one full reference period and then holds it closed for the next. While the gate is open, a cascade of decade counters advances on every rising edge of the measured signal.

When the gate closes, the count is copied into a holding register and stays there through the next full measurement. The counters are then cleared during the low half of the closed period. Each held digit drives its own segment decoder, so the display changes only once per two reference periods. With a 1 Hz reference, the held number reads directly in hertz. Readings wrap modulo 10^N for N digits.

The clear is synchronous to the measured signal. The reference edges and the clear window must therefore be separated from measured edges by at least one measured period, which holds whenever the measured rate is well above the reference rate.

Top module: `freq_meter4`

## Requirements
- R1: `held_bcd` carries one 4-bit BCD digit per display, with digit k (k=0 least significant) at bits [4k+3:4k]. After each gate, it equals the number of `sig_in` rising edges seen while that gate was open.
- R2: A digit at 9 that advances returns to 0 and carries one into the next digit. The top digit wraps from 9 to 0 with no flag, so with four digits a gate holding 10005 edges reads 0005 and a carried-over count of 9999 plus 2 reads 0001.
- R3: Rising edges of `sig_in` while the gate is closed do not change the count.
- R4: The gate opens at the first `ref_clk` rising edge after reset and then changes state on every `ref_clk` rising edge. It is open for exactly one reference period out of every two.
- R5: `held_bcd` is captured at the `ref_clk` rising edge that closes the gate. It stays unchanged through the following closed and open periods until the next closing edge.
- R6: The counters are cleared by `sig_in` rising edges that occur while both `ref_clk` and the gate are low. If no such edge occurs, the next gate adds onto the previous count.
- R7: `seg_bus` holds seven active-high segments per digit. Digit k is at bits [7k+6:7k], with bit 0 = segment a through bit 6 = segment g. The patterns (g..a) are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R8: While `rst` is high, the gate flag, the counters and `held_bcd` are cleared asynchronously, so every digit displays the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that sets the gate time |
| sig_in | input | 1 | Pulse train being measured |
| rst | input | 1 | Asynchronous reset, active high |
| held_bcd | output | 16 | Held reading, four BCD digits |
| seg_bus | output | 28 | Seven segment lines per digit, active high |

## Verification
The hardest behaviour to reach from the ports is the clear that is missing or mistimed. A reading is correct only if the counters were cleared by measured edges inside the reference-low half of the closed period, and if edges in the closed-high half were ignored. The stimulus places bursts of measured pulses in the closed-high window of every cycle. In one cycle it deliberately omits pulses in the clear window, so the next gate must carry on from 9999 and wrap to 0001. That exposes counting while closed, clearing at the wrong time, and a broken carry chain together.

// File: rtl/fm_pkg.sv
package fm_pkg;
   localparam int BCD_W = 4;
   localparam int SEG_W = 7;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // segment order g..a, active high; codes above 9 give hex letters
   function automatic seg_t bcd_to_seg(input bcd_t d);
      seg_t s;
      case (d)
         4'd0:    s = 7'b0111111;
         4'd1:    s = 7'b0000110;
         4'd2:    s = 7'b1011011;
         4'd3:    s = 7'b1001111;
         4'd4:    s = 7'b1100110;
         4'd5:    s = 7'b1101101;
         4'd6:    s = 7'b1111101;
         4'd7:    s = 7'b0000111;
         4'd8:    s = 7'b1111111;
         4'd9:    s = 7'b1101111;
         4'd10:   s = 7'b1110111;
         4'd11:   s = 7'b1111100;
         4'd12:   s = 7'b0111001;
         4'd13:   s = 7'b1011110;
         4'd14:   s = 7'b1111001;
         default: s = 7'b1110001;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/fm_gate_ctrl.sv
module fm_gate_ctrl (
   input  logic ref_clk,
   input  logic rst,
   output logic gate_en,
   output logic load_stb,
   output logic clr_cnt
);
   logic phase_q;

   always_ff @(posedge ref_clk or posedge rst) begin
      if (rst) phase_q <= 1'b0;
      else     phase_q <= ~phase_q;
   end

   assign gate_en  = phase_q;
   assign load_stb = ~phase_q;
   // clear window: second half of the closed period, after capture
   assign clr_cnt  = ~ref_clk & ~phase_q;
endmodule

// File: rtl/fm_decade_chain.sv
module fm_decade_chain #(
   parameter int NUM_DIGITS = 4
) (
   input  logic                                  sig_in,
   input  logic                                  rst,
   input  logic                                  gate_en,
   input  logic                                  clr_cnt,
   output logic [NUM_DIGITS*fm_pkg::BCD_W-1:0]   cnt_bcd
);
   import fm_pkg::*;

   logic [NUM_DIGITS-1:0] step;
   assign step[0] = gate_en;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
      bcd_t dig_q;
      logic at_nine;

      assign at_nine = (dig_q == 4'd9);

      if (k < NUM_DIGITS - 1) begin : g_carry
         assign step[k+1] = step[k] & at_nine;
      end

      always_ff @(posedge sig_in or posedge rst) begin
         if (rst)           dig_q <= '0;
         else if (clr_cnt)  dig_q <= '0;
         else if (step[k])  dig_q <= at_nine ? '0 : dig_q + 4'd1;
      end

      assign cnt_bcd[k*BCD_W +: BCD_W] = dig_q;
   end
endmodule

// File: rtl/fm_hold_reg.sv
module fm_hold_reg #(
   parameter int WIDTH = 16
) (
   input  logic             load_stb,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   always_ff @(posedge load_stb or posedge rst) begin
      if (rst) dout <= '0;
      else     dout <= din;
   end
endmodule

// File: rtl/fm_seg_drive.sv
module fm_seg_drive #(
   parameter int NUM_DIGITS     = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic [NUM_DIGITS*fm_pkg::BCD_W-1:0] held_bcd,
   output logic [NUM_DIGITS*fm_pkg::SEG_W-1:0] seg_bus
);
   import fm_pkg::*;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_seg
      seg_t pat;
      assign pat = bcd_to_seg(held_bcd[k*BCD_W +: BCD_W]);
      if (SEG_ACTIVE_LOW) begin : g_low
         assign seg_bus[k*SEG_W +: SEG_W] = ~pat;
      end else begin : g_high
         assign seg_bus[k*SEG_W +: SEG_W] = pat;
      end
   end
endmodule

// File: rtl/freq_meter4.sv
module freq_meter4 #(
   parameter int NUM_DIGITS     = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                                 ref_clk,
   input  logic                                 sig_in,
   input  logic                                 rst,
   output logic [NUM_DIGITS*fm_pkg::BCD_W-1:0]  held_bcd,
   output logic [NUM_DIGITS*fm_pkg::SEG_W-1:0]  seg_bus
);
   localparam int CNT_W = NUM_DIGITS * fm_pkg::BCD_W;

   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("freq_meter4: NUM_DIGITS must lie in 1..8");
   end

   logic             gate_en;
   logic             load_stb;
   logic             clr_cnt;
   logic [CNT_W-1:0] cnt_bcd;

   fm_gate_ctrl u_ctrl (
      .ref_clk  (ref_clk),
      .rst      (rst),
      .gate_en  (gate_en),
      .load_stb (load_stb),
      .clr_cnt  (clr_cnt)
   );

   fm_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
      .sig_in  (sig_in),
      .rst     (rst),
      .gate_en (gate_en),
      .clr_cnt (clr_cnt),
      .cnt_bcd (cnt_bcd)
   );

   fm_hold_reg #(.WIDTH(CNT_W)) u_hold (
      .load_stb (load_stb),
      .rst      (rst),
      .din      (cnt_bcd),
      .dout     (held_bcd)
   );

   fm_seg_drive #(.NUM_DIGITS(NUM_DIGITS), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg (
      .held_bcd (held_bcd),
      .seg_bus  (seg_bus)
   );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
   parameter int NUM_DIGITS = 4
) (
   input logic                      ref_clk,
   input logic                      sig_in,
   input logic                      rst,
   input logic                      gate_en,
   input logic                      clr_cnt,
   input logic [NUM_DIGITS*4-1:0]   cnt_bcd,
   input logic [NUM_DIGITS*4-1:0]   held_bcd
);
   AST_GATE_TOGGLE: assert property (@(posedge ref_clk) disable iff (rst)
      gate_en |=> !gate_en); // R4

   AST_GATE_REOPEN: assert property (@(posedge ref_clk) disable iff (rst)
      !gate_en |=> gate_en); // R4

   AST_HOLD_STABLE: assert property (@(posedge ref_clk) disable iff (rst)
      !gate_en |=> $stable(held_bcd)); // R5

   AST_HOLD_CAPTURE: assert property (@(posedge ref_clk) disable iff (rst)
      gate_en |=> (held_bcd == $past(cnt_bcd))); // R1

   AST_IDLE_WHEN_CLOSED: assert property (@(posedge sig_in) disable iff (rst)
      (!gate_en && !clr_cnt) |=> $stable(cnt_bcd)); // R3

   AST_CLEAR_ZERO: assert property (@(posedge sig_in) disable iff (rst)
      clr_cnt |=> (cnt_bcd == '0)); // R6

   AST_CLEAR_ONLY_CLOSED: assert property (@(posedge sig_in) disable iff (rst)
      clr_cnt |-> !gate_en); // R6

   AST_LOW_DIGIT_STEP: assert property (@(posedge sig_in) disable iff (rst)
      (gate_en && !clr_cnt && cnt_bcd[3:0] != 4'd9)
         |=> (cnt_bcd[3:0] == $past(cnt_bcd[3:0]) + 4'd1)); // R2

   AST_LOW_DIGIT_WRAP: assert property (@(posedge sig_in) disable iff (rst)
      (gate_en && !clr_cnt && cnt_bcd[3:0] == 4'd9) |=> (cnt_bcd[3:0] == 4'd0)); // R2
endmodule

bind freq_meter4 fm_checker #(.NUM_DIGITS(NUM_DIGITS)) i_fm_checker (
   .ref_clk  (ref_clk),
   .sig_in   (sig_in),
   .rst      (rst),
   .gate_en  (gate_en),
   .clr_cnt  (clr_cnt),
   .cnt_bcd  (cnt_bcd),
   .held_bcd (held_bcd)
);

// File: tb/test_freq_meter4.sv
`timescale 1ns/1ps
module test_freq_meter4;
   localparam int ND       = 4;
   localparam int MODV     = 10000;
   localparam int REF_HALF = 5100;
   localparam int REF_P    = 2 * REF_HALF;
   localparam int MARGIN   = 60;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic ref_clk = 1'b0;
   logic sig_en  = 1'b0;
   logic rst     = 1'b1;
   logic sig_in;
   assign sig_in = clk & sig_en;

   logic [ND*4-1:0] held_bcd;
   logic [ND*7-1:0] seg_bus;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   int acc   = 0;
   int shown = 0;

   freq_meter4 i_freq_meter4 (
      .ref_clk  (ref_clk),
      .sig_in   (sig_in),
      .rst      (rst),
      .held_bcd (held_bcd),
      .seg_bus  (seg_bus)
   );

   function automatic logic [ND*4-1:0] to_bcd(input int v);
      logic [ND*4-1:0] r;
      int rest;
      rest = v;
      for (int k = 0; k < ND; k++) begin
         r[k*4 +: 4] = 4'(rest % 10);
         rest = rest / 10;
      end
      return r;
   endfunction

   function automatic logic [6:0] seg_of(input int d);
      case (d)
         0: return 7'b0111111;
         1: return 7'b0000110;
         2: return 7'b1011011;
         3: return 7'b1001111;
         4: return 7'b1100110;
         5: return 7'b1101101;
         6: return 7'b1111101;
         7: return 7'b0000111;
         8: return 7'b1111111;
         default: return 7'b1101111;
      endcase
   endfunction

   task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_display(input string tag, input int v);
      logic [ND*4-1:0] eb;
      eb = to_bcd(v);
      check_val(tag, 32'(held_bcd), 32'(eb));
      for (int k = 0; k < ND; k++)
         check_val({tag, " R7 segments"}, 32'(seg_bus[k*7 +: 7]), 32'(seg_of(int'(eb[k*4 +: 4]))));
   endtask

   // one open gate of n pulses, then one closed period; clear edges optional
   task automatic measure(input int n, input bit clr_after, input string tag);
      int exp_v;
      exp_v = (acc + n) % MODV;
      for (int i = 0; i < REF_P; i++) begin
         @(negedge clk);
         if (i == 0)        ref_clk = 1'b1;
         if (i == REF_HALF) ref_clk = 1'b0;
         sig_en = (i >= MARGIN) && (i < MARGIN + n);
         if (i == REF_HALF + 20) check_val("R5 held during gate", 32'(held_bcd), 32'(to_bcd(shown)));
      end
      for (int i = 0; i < REF_P; i++) begin
         @(negedge clk);
         if (i == 0)        ref_clk = 1'b1;
         if (i == REF_HALF) ref_clk = 1'b0;
         // closed-high burst must be ignored (R3); closed-low burst clears (R6)
         sig_en = ((i >= 100) && (i < 150)) ||
                  (clr_after && (i >= REF_HALF + 100) && (i < REF_HALF + 130));
         if (i == 20) check_display(tag, exp_v);
      end
      shown = exp_v;
      acc   = clr_after ? 0 : exp_v;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_display("R8 reset", 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check_display("R8 after release", 0);
      measure(0,     1'b1, "R8 first gate R1");
      measure(7,     1'b1, "R1");
      measure(1234,  1'b1, "R1 R7");
      measure(9999,  1'b0, "R2 R3");
      measure(2,     1'b1, "R6 R2 R3");
      measure(10005, 1'b1, "R4 R2");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule